// File: doc/BRIEF.md
# SPI Parameter-Table Read Responder

This block is an SPI slave that answers a single read command against a 256-byte parameter table. After chip select falls, the host shifts in an 8-bit command code, a 24-bit start address and eight dummy clocks. From then on the block returns table bytes on the data output, one after another, for as long as chip select stays low. The start address comes from the low byte of the address field. The read pointer steps by one after each byte and wraps at the end of the table.

The whole block runs on one system clock. The SPI clock, chip select and data input each pass through a synchronizer, and the SPI edges are detected as single-cycle events. The table is filled through a valid/ready load port. This port takes beats only while no SPI transaction is open. Because the block oversamples the SPI pins, each SPI clock half-period must last at least `SYNC_STAGES + 2` system clock cycles.

Top module: `ptab_spi_responder`

## Requirements
- R1: The command code is 0x5A, received MSB first and sampled on rising SPI clock edges. Any other code keeps `miso_oe` low for the rest of the transaction.
- R2: The 24-bit address is received MSB first. Bits 7..0 choose the first byte sent. Bits 23..8 are ignored and raise no error.
- R3: `miso_oe` stays low through the 40 header clocks (8 command, 24 address, 8 dummy). The first data bit is driven on the falling edge that follows the 40th rising edge.
- R4: `miso` changes only after a falling SPI clock edge. Each byte goes out MSB first.
- R5: Bytes stream back to back while chip select is low. The table index increases by one per byte and wraps from 255 to 0.
- R6: Raising `cs_n` forces `miso_oe` low at once. It also returns the block to the command phase, so the next transaction decodes from its first bit.
- R7: The block works with the SPI clock idling low (mode 0) and idling high (mode 3).
- R8: `ld_ready` is high only while the synchronized chip select is high. A beat writes `ld_data` to entry `ld_addr` on a clock where `ld_valid` and `ld_ready` are both high. A beat presented while `ld_ready` is low stays pending and has no effect on the table until it is accepted.
- R9: After reset all table entries are zero, `miso_oe` is low and `ld_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI serial data in |
| miso | output | 1 | SPI serial data out |
| miso_oe | output | 1 | Output enable for `miso`; low means high impedance |
| ld_valid | input | 1 | Load beat valid |
| ld_ready | output | 1 | Load port can accept a beat |
| ld_addr | input | 8 | Table entry to write |
| ld_data | input | 8 | Byte to write |

## Verification
The hardest case to reach is a load beat that arrives while a transaction is open and must wait. The stimulus runs a streaming read alongside a concurrent process that raises `ld_valid` part way into the header. The read covers the entry that the pending beat targets, so the old byte must appear on `miso`. Once chip select rises, the beat is accepted, and a second read must return the new byte. The sweep also covers start addresses in steps of five in both clock polarities, a stream longer than the table to exercise the wrap, an address with nonzero upper bits, a rejected command, and aborts in the header and in the data phase.

// File: rtl/ptab_pkg.sv
package ptab_pkg;
  typedef enum logic [2:0] {
    PH_OPC = 3'd0,
    PH_ADR = 3'd1,
    PH_DUM = 3'd2,
    PH_DAT = 3'd3,
    PH_REJ = 3'd4
  } phase_e;
endpackage

// File: rtl/ptab_pin_sync.sv
module ptab_pin_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ptab_store.sv
module ptab_store #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/ptab_cmd_fsm.sv
module ptab_cmd_fsm
  import ptab_pkg::*;
#(
  parameter int OPC_BITS = 8,
  parameter logic [OPC_BITS-1:0] OPCODE = 8'h5A,
  parameter int ADDR_BITS = 24,
  parameter int DUMMY_CLKS = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          sclk_s,
  input  logic          mosi_s,
  output phase_e        phase,
  output logic          fall,
  output logic [AW-1:0] start_addr,
  output logic          idle_q
);
  localparam int MAXC = (ADDR_BITS > OPC_BITS) ?
                        ((ADDR_BITS > DUMMY_CLKS) ? ADDR_BITS : DUMMY_CLKS) :
                        ((OPC_BITS > DUMMY_CLKS) ? OPC_BITS : DUMMY_CLKS);
  localparam int CW = $clog2(MAXC + 1);

  logic                sclk_q;
  logic                rise;
  logic [CW-1:0]       cnt;
  logic [OPC_BITS-1:0] op_sh;
  logic [AW-1:0]       adr_sh;
  logic [OPC_BITS-1:0] op_next;

  assign rise       = sclk_s & ~sclk_q;
  assign fall       = ~sclk_s & sclk_q;
  assign op_next    = {op_sh[OPC_BITS-2:0], mosi_s};
  assign start_addr = adr_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      idle_q <= 1'b1;
      phase  <= PH_OPC;
      cnt    <= '0;
      op_sh  <= '0;
      adr_sh <= '0;
    end else begin
      sclk_q <= sclk_s;
      idle_q <= cs_s;
      if (cs_s) begin
        phase <= PH_OPC;
        cnt   <= '0;
      end else if (rise) begin
        unique case (phase)
          PH_OPC: begin
            op_sh <= op_next;
            if (cnt == CW'(OPC_BITS - 1)) begin
              cnt   <= '0;
              phase <= (op_next == OPCODE) ? PH_ADR : PH_REJ;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_ADR: begin
            adr_sh <= {adr_sh[AW-2:0], mosi_s};
            if (cnt == CW'(ADDR_BITS - 1)) begin
              cnt   <= '0;
              phase <= PH_DUM;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_DUM: begin
            if (cnt == CW'(DUMMY_CLKS - 1)) begin
              cnt   <= '0;
              phase <= PH_DAT;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_idle_on_deselect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (phase == PH_OPC && cnt == '0));
endmodule

// File: rtl/ptab_shifter.sv
module ptab_shifter #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          fall,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          miso_q,
  output logic          oe_q
);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;

  logic [AW-1:0] ptr;
  logic [DW-1:0] tx;
  logic [BW-1:0] bit_cnt;

  assign rd_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr     <= '0;
      tx      <= '0;
      bit_cnt <= '0;
      miso_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else if (!active) begin
      ptr     <= start_addr;
      bit_cnt <= '0;
      oe_q    <= 1'b0;
    end else if (fall) begin
      oe_q <= 1'b1;
      if (bit_cnt == '0) begin
        miso_q <= rd_data[DW-1];
        tx     <= {rd_data[DW-2:0], 1'b0};
        ptr    <= ptr + 1'b1;
      end else begin
        miso_q <= tx[DW-1];
        tx     <= {tx[DW-2:0], 1'b0};
      end
      bit_cnt <= (bit_cnt == BW'(DW - 1)) ? '0 : bit_cnt + 1'b1;
    end
  end

  assert_oe_only_in_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> $past(active));
  assert_miso_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(miso_q));
endmodule

// File: rtl/ptab_spi_responder.sv
module ptab_spi_responder
  import ptab_pkg::*;
#(
  parameter logic [7:0] OPCODE = 8'h5A,
  parameter int ADDR_BITS = 24,
  parameter int DUMMY_CLKS = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  output logic       miso,
  output logic       miso_oe,
  input  logic       ld_valid,
  output logic       ld_ready,
  input  logic [7:0] ld_addr,
  input  logic [7:0] ld_data
);
  localparam int AW = 8;
  localparam int DW = 8;

  logic [2:0]    pins_s;
  phase_e        phase;
  logic          fall;
  logic          idle_q;
  logic [AW-1:0] start_addr;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic          miso_q;
  logic          oe_q;

  ptab_pin_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sclk, cs_n, mosi}), .q(pins_s));

  ptab_cmd_fsm #(.OPC_BITS(8), .OPCODE(OPCODE), .ADDR_BITS(ADDR_BITS),
                 .DUMMY_CLKS(DUMMY_CLKS), .AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cs_s(pins_s[1]), .sclk_s(pins_s[2]),
    .mosi_s(pins_s[0]), .phase(phase), .fall(fall),
    .start_addr(start_addr), .idle_q(idle_q));

  ptab_store #(.AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(ld_valid && ld_ready),
    .wr_addr(ld_addr), .wr_data(ld_data), .rd_addr(rd_addr), .rd_data(rd_data));

  ptab_shifter #(.AW(AW), .DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .active(phase == PH_DAT), .fall(fall),
    .start_addr(start_addr), .rd_data(rd_data), .rd_addr(rd_addr),
    .miso_q(miso_q), .oe_q(oe_q));

  assign ld_ready = idle_q;
  assign miso     = miso_q;
  assign miso_oe  = oe_q & ~cs_n;

  assert_reject_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_REJ) |-> !miso_oe);
  assert_load_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |-> (phase == PH_OPC));
endmodule

// File: tb/ptab_spi_responder_bench.sv
module ptab_spi_responder_bench;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe;
  logic ld_valid = 1'b0;
  logic ld_ready;
  logic [7:0] ld_addr = '0, ld_data = '0;

  int total = 0, bad = 0;
  logic [7:0] exp_tab [256];

  always #2 clk = ~clk;

  ptab_spi_responder u_ptab_spi_responder (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_data(ld_data));

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(int sel, int i);
    return (sel == 0) ? 8'((i * 37 + 11) & 255) : 8'((i ^ 8'hA5) + 3);
  endfunction

  task automatic load_table(int sel);
    @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      ld_valid = 1'b1; ld_addr = 8'(i); ld_data = pat(sel, i);
      while (!ld_ready) @(negedge clk);
      @(negedge clk);
      exp_tab[i] = pat(sel, i);
    end
    ld_valid = 1'b0;
  endtask

  task automatic xfer(bit m3, logic [7:0] op, logic [23:0] adr, int nbytes,
                      int abort_at, string req);
    logic [39:0] hdr;
    logic [7:0] b;
    bit oe_seen;
    bit good;
    int nclk;
    hdr = {op, adr, 8'h00};
    b = '0;
    oe_seen = 0;
    good = (op == 8'h5A);
    nclk = 40 + nbytes * 8;
    sclk = m3; cs_n = 1'b1;
    wait_clk(HALF);
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int k = 0; k < nclk; k++) begin
      if (abort_at >= 0 && k == abort_at) break;
      sclk = 1'b0;
      mosi = (k < 40) ? hdr[39-k] : 1'b0;
      wait_clk(HALF);
      if (k < 40 || !good) begin
        if (miso_oe) oe_seen = 1;
      end else begin
        b = {b[6:0], miso};
        if (!miso_oe) oe_seen = 1;
        if (((k - 40) % 8) == 7)
          check(b == exp_tab[8'(adr[7:0] + (k - 40) / 8)], req, b,
                exp_tab[8'(adr[7:0] + (k - 40) / 8)]);
      end
      if (k == 5) check(ld_ready == 1'b0, "R8 ready low while selected", ld_ready, 0);
      sclk = 1'b1;
      wait_clk(HALF);
    end
    // header quiet (R3), rejected command silent (R1)
    check(!oe_seen, good ? "R3 oe in header/data gap" : "R1 oe after bad opcode", oe_seen, 0);
    sclk = m3;
    wait_clk(HALF);
    cs_n = 1'b1;
    #1;
    check(miso_oe == 1'b0, "R6 oe drop on deselect", miso_oe, 0);
    wait_clk(HALF);
    check(ld_ready == 1'b1, "R8 ready back after deselect", ld_ready, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) exp_tab[i] = '0;
    wait_clk(3);
    // R9: reset state
    check(miso_oe == 1'b0, "R9 reset oe", miso_oe, 0);
    check(ld_ready == 1'b1, "R9 reset ready", ld_ready, 1);
    rst_n = 1'b1;
    wait_clk(4);
    xfer(0, 8'h5A, 24'h000010, 2, -1, "R9 table zero after reset");

    load_table(0);
    // R2 R4 R7: sweep start addresses in both clock polarities
    for (int a = 0; a < 256; a += 5)
      xfer(a[0], 8'h5A, 24'(a), 3, -1, a[0] ? "R7 mode3 sweep R2 R4" : "R2 R4 mode0 sweep");
    // R5: wrap at the table end, then one stream longer than the table
    xfer(0, 8'h5A, 24'h0000FE, 4, -1, "R5 wrap 254..1");
    xfer(1, 8'h5A, 24'h000000, 258, -1, "R5 long stream");
    // R2: upper address bits ignored
    xfer(1, 8'h5A, 24'hABCD10, 2, -1, "R2 upper bits ignored");
    // R1: wrong command codes stay silent
    xfer(0, 8'h5B, 24'h000000, 3, -1, "R1 reject");
    xfer(1, 8'hDA, 24'h000000, 3, -1, "R1 reject");
    // R6: aborts in header and in data, then fresh transactions
    xfer(0, 8'h5A, 24'h000033, 3, 20, "R6 abort header");
    xfer(0, 8'h5A, 24'h000033, 2, -1, "R6 fresh after abort");
    xfer(1, 8'h5A, 24'h000080, 3, 52, "R6 abort data");
    xfer(1, 8'h5A, 24'h000081, 2, -1, "R6 fresh after data abort");

    // R8: pending load during a transaction must not touch entry 7 yet
    fork
      xfer(0, 8'h5A, 24'h000006, 2, -1, "R8 old value while beat pending");
      begin
        wait_clk(20);
        ld_valid = 1'b1; ld_addr = 8'd7; ld_data = 8'hC3;
        while (!ld_ready) @(negedge clk);
        @(negedge clk);
        ld_valid = 1'b0;
        exp_tab[7] = 8'hC3;
      end
    join
    xfer(0, 8'h5A, 24'h000007, 1, -1, "R8 beat applied after deselect");

    load_table(1);
    xfer(1, 8'h5A, 24'h0000F0, 20, -1, "R8 R5 reload pattern");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule